// File: doc/BRIEF.md
# Canonical Huffman First-Code Table Builder

This block turns the per-length code counts of one canonical Huffman table into the lookup data a bitstream decoder needs. The counts are 16 bytes per table and sit in a shared byte-wide block RAM. The RAM returns data one clock after it is addressed. When the block is asked to build, it reads the 16 count bytes of the selected table in order, one address per cycle. From them it works out two values for each code length from 1 to 16 and writes them into a small register file:

- the first (lowest) code of that length;
- the symbol base, which is the number of symbols whose codes are shorter.

The decoder then gives a code length on the lookup port and gets both values back in the same cycle. It forms the symbol address as base + (code - first code). The symbol bytes are kept from address 0 upward in the same RAM. The table can be rebuilt from the RAM whenever a different table is needed. Nothing else in the chip has to hold it.

The controller has four states. IDLE waits for a start. FETCH issues the 16 count-byte reads. DRAIN waits for the data of the last read. FINISH raises the done pulse. The transitions are:

- IDLE to FETCH when start is seen. This latches the table select and clears the running sums.
- FETCH to FETCH while reads remain.
- FETCH to DRAIN after the read for length 16.
- DRAIN to FINISH unconditionally.
- FINISH to IDLE unconditionally.

A start that arrives in any state other than IDLE is dropped.

Top module: `huff_first_code_builder`

## Requirements
- R1: After reset, done and busy are low, no RAM read is issued, and every lookup entry returns first code 0 and symbol base 0.
- R2: A start seen in IDLE makes busy high from the next cycle. It issues exactly 16 reads on 16 consecutive cycles, to addresses 0x6C0 + 16*sel + k for k = 0..15, where sel is the 2-bit table select sampled with the start. The read strobe is low in every other cycle.
- R3: The first code for length 1 is 0. For length L+1 it is ((first code of L) + count of L) shifted left by one bit, kept to 16 bits. The count of length L is the byte at offset L-1 of the table.
- R4: The symbol base for length L is the sum of the counts of lengths 1 to L-1, kept to 12 bits.
- R5: The last entry is written at the end of the cycle after the final read. Done is high for exactly one cycle, the cycle after that write, which is 18 cycles after the cycle that carried the start. Busy falls in the cycle after done.
- R6: A start or a table-select change while busy has no effect. The address sequence, the done timing and the resulting entries are those of the build that was accepted.
- R7: The lookup index i (0..15) returns the entry for code length i+1 combinationally. While idle, the entries hold their values until the next build.
- R8: Each build overwrites all 16 entries, so building a different table replaces every value left by the previous one.
- R9: Each count byte is taken from the RAM data input in the cycle after its address was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Build request, sampled only in IDLE |
| table_sel_i | input | 2 | Table to build, latched with the start |
| mem_rd_o | output | 1 | RAM read strobe |
| mem_addr_o | output | 11 | RAM byte address |
| mem_data_i | input | 8 | RAM read data, valid one cycle after the address |
| busy_o | output | 1 | Build in progress, done cycle included |
| done_o | output | 1 | One-cycle completion pulse |
| lk_len_i | input | 4 | Lookup index, code length minus one |
| lk_first_o | output | 16 | First code for the looked-up length |
| lk_base_o | output | 12 | Symbol base for the looked-up length |

## Verification
The assertions assume the RAM behaves as a one-cycle-latency read port. They also assume it never asks for more than the strobe offers. The checks are:

- every read falls inside the count region and steps by one from the previous read;
- done follows the last read by exactly two cycles;
- the lookup outputs stay still while the block is idle and the index does not move.

The bench models the RAM with a registered read, so the data arrives exactly as assumed. It drives start and select only at falling edges. It sweeps all four tables under six count patterns: empty, typical DC, typical AC, saturated, a single length, and table-dependent pseudo-random. The patterns are rotated across the tables, so a wrong table offset shows up as a mismatch.

// File: rtl/hfb_pkg.sv
`timescale 1ns/1ps
package hfb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN,
        ST_FINISH
    } hfb_state_e;
endpackage

// File: rtl/hfb_addr_gen.sv
`timescale 1ns/1ps
module hfb_addr_gen #(
    parameter int          ADDR_W     = 11,
    parameter int          TAB_W      = 2,
    parameter int          LEN_W      = 4,
    parameter int          NUM_LEN    = 16,
    parameter int unsigned CNT_REGION = 'h6C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [TAB_W-1:0]  tab_i,
    output logic [LEN_W-1:0]  idx_o,
    output logic              last_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [TAB_W-1:0] tab_q;
    logic [LEN_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            tab_q <= tab_i;
            idx_q <= '0;
        end else if (step_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == LEN_W'(NUM_LEN - 1));
    assign addr_o = ADDR_W'(CNT_REGION)
                  + (ADDR_W'(tab_q) << LEN_W)
                  + ADDR_W'(idx_q);
endmodule

// File: rtl/hfb_accum.sv
`timescale 1ns/1ps
module hfb_accum #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 16,
    parameter int BASE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] cnt_i,
    output logic [CODE_W-1:0] first_o,
    output logic [BASE_W-1:0] base_o
);
    logic [CODE_W-1:0] first_q;
    logic [BASE_W-1:0] base_q;
    logic [CODE_W-1:0] sum;
    logic [CODE_W-1:0] first_nxt;
    logic [BASE_W-1:0] base_nxt;

    always_comb begin
        sum       = first_q + CODE_W'(cnt_i);
        first_nxt = {sum[CODE_W-2:0], 1'b0};
        base_nxt  = base_q + BASE_W'(cnt_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= '0;
            base_q  <= '0;
        end else if (clear_i) begin
            first_q <= '0;
            base_q  <= '0;
        end else if (upd_i) begin
            first_q <= first_nxt;
            base_q  <= base_nxt;
        end
    end

    assign first_o = first_q;
    assign base_o  = base_q;
endmodule

// File: rtl/hfb_regfile.sv
`timescale 1ns/1ps
module hfb_regfile #(
    parameter int NUM_LEN = 16,
    parameter int LEN_W   = 4,
    parameter int CODE_W  = 16,
    parameter int BASE_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [LEN_W-1:0]  widx_i,
    input  logic [CODE_W-1:0] wfirst_i,
    input  logic [BASE_W-1:0] wbase_i,
    input  logic [LEN_W-1:0]  ridx_i,
    output logic [CODE_W-1:0] rfirst_o,
    output logic [BASE_W-1:0] rbase_o
);
    logic [CODE_W-1:0] first_q [NUM_LEN];
    logic [BASE_W-1:0] base_q  [NUM_LEN];

    for (genvar g = 0; g < NUM_LEN; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                first_q[g] <= '0;
                base_q[g]  <= '0;
            end else if (we_i && (widx_i == LEN_W'(g))) begin
                first_q[g] <= wfirst_i;
                base_q[g]  <= wbase_i;
            end
        end
    end

    assign rfirst_o = first_q[ridx_i];
    assign rbase_o  = base_q[ridx_i];
endmodule

// File: rtl/huff_first_code_builder.sv
`timescale 1ns/1ps
module huff_first_code_builder #(
    parameter int          ADDR_W     = 11,
    parameter int          DATA_W     = 8,
    parameter int          NUM_LEN    = 16,
    parameter int          NUM_TAB    = 4,
    parameter int          CODE_W     = 16,
    parameter int          BASE_W     = 12,
    parameter int unsigned CNT_REGION = 'h6C0,
    localparam int         LEN_W      = $clog2(NUM_LEN),
    localparam int         TAB_W      = $clog2(NUM_TAB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TAB_W-1:0]  table_sel_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              busy_o,
    output logic              done_o,
    input  logic [LEN_W-1:0]  lk_len_i,
    output logic [CODE_W-1:0] lk_first_o,
    output logic [BASE_W-1:0] lk_base_o
);
    import hfb_pkg::*;

    hfb_state_e        state_q, state_d;
    logic              load, step, last;
    logic [LEN_W-1:0]  idx;
    logic              rd_vld_q;
    logic [LEN_W-1:0]  rd_idx_q;
    logic [CODE_W-1:0] acc_first;
    logic [BASE_W-1:0] acc_base;

    // State register and next-state logic
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_FETCH;
            ST_FETCH:  if (last)    state_d = ST_DRAIN;
            ST_DRAIN:               state_d = ST_FINISH;
            ST_FINISH:              state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        load     = 1'b0;
        step     = 1'b0;
        mem_rd_o = 1'b0;
        busy_o   = 1'b1;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                load   = start_i;
            end
            ST_FETCH: begin
                mem_rd_o = 1'b1;
                step     = !last;
            end
            ST_DRAIN:  ;
            ST_FINISH: done_o = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

    // Read-return tracking: data of the read issued last cycle is valid now
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_q <= 1'b0;
            rd_idx_q <= '0;
        end else begin
            rd_vld_q <= mem_rd_o;
            rd_idx_q <= idx;
        end
    end

    hfb_addr_gen #(
        .ADDR_W(ADDR_W), .TAB_W(TAB_W), .LEN_W(LEN_W),
        .NUM_LEN(NUM_LEN), .CNT_REGION(CNT_REGION)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .tab_i(table_sel_i), .idx_o(idx), .last_o(last), .addr_o(mem_addr_o)
    );

    hfb_accum #(
        .DATA_W(DATA_W), .CODE_W(CODE_W), .BASE_W(BASE_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .clear_i(load), .upd_i(rd_vld_q),
        .cnt_i(mem_data_i), .first_o(acc_first), .base_o(acc_base)
    );

    hfb_regfile #(
        .NUM_LEN(NUM_LEN), .LEN_W(LEN_W), .CODE_W(CODE_W), .BASE_W(BASE_W)
    ) u_rf (
        .clk(clk), .rst_n(rst_n), .we_i(rd_vld_q), .widx_i(rd_idx_q),
        .wfirst_i(acc_first), .wbase_i(acc_base), .ridx_i(lk_len_i),
        .rfirst_o(lk_first_o), .rbase_o(lk_base_o)
    );
endmodule

// File: rtl/hfb_checker.sv
`timescale 1ns/1ps
module hfb_checker #(
    parameter int          ADDR_W     = 11,
    parameter int          NUM_LEN    = 16,
    parameter int          NUM_TAB    = 4,
    parameter int          CODE_W     = 16,
    parameter int          BASE_W     = 12,
    parameter int unsigned CNT_REGION = 'h6C0,
    parameter int          LEN_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [LEN_W-1:0]  lk_len_i,
    input logic [CODE_W-1:0] lk_first_o,
    input logic [BASE_W-1:0] lk_base_o
);
    localparam int CNT_W = $clog2(NUM_LEN + 1);
    logic [CNT_W-1:0] rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_cnt <= '0;
        else if (done_o)   rd_cnt <= '0;
        else if (mem_rd_o) rd_cnt <= rd_cnt + 1'b1;
    end

    p_addr_in_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> (32'(mem_addr_o) >= CNT_REGION) &&
                     (32'(mem_addr_o) < CNT_REGION + NUM_TAB * NUM_LEN));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_o) |=> done_o);

    p_read_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> rd_cnt == CNT_W'(NUM_LEN));

    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    p_lookup_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o) && $stable(lk_len_i)) |->
            ($stable(lk_first_o) && $stable(lk_base_o)));
endmodule

bind huff_first_code_builder hfb_checker #(
    .ADDR_W(ADDR_W), .NUM_LEN(NUM_LEN), .NUM_TAB(NUM_TAB), .CODE_W(CODE_W),
    .BASE_W(BASE_W), .CNT_REGION(CNT_REGION), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .busy_o(busy_o), .done_o(done_o), .lk_len_i(lk_len_i),
    .lk_first_o(lk_first_o), .lk_base_o(lk_base_o)
);

// File: tb/tb_huff_first_code_builder.sv
`timescale 1ns/1ps
module tb_huff_first_code_builder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  table_sel_i = '0;
    logic        mem_rd_o;
    logic [10:0] mem_addr_o;
    logic [7:0]  mem_data_i;
    logic        busy_o, done_o;
    logic [3:0]  lk_len_i = '0;
    logic [15:0] lk_first_o;
    logic [11:0] lk_base_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] ram [2048];

    always #2 clk = ~clk;

    huff_first_code_builder dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .table_sel_i(table_sel_i),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
        .busy_o(busy_o), .done_o(done_o), .lk_len_i(lk_len_i),
        .lk_first_o(lk_first_o), .lk_base_o(lk_base_o)
    );

    // One-cycle-latency RAM model (R9)
    always @(posedge clk) if (mem_rd_o) mem_data_i <= ram[mem_addr_o];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] cnt_of(int pat, int tab, int l);
        logic [7:0] dc [16] = '{0,1,5,1,1,1,1,1,1,0,0,0,0,0,0,0};
        logic [7:0] ac [16] = '{0,2,1,3,3,2,4,3,5,5,4,4,0,0,1,125};
        case (pat)
            0:       return 8'd0;
            1:       return dc[l];
            2:       return ac[l];
            3:       return 8'd255;
            4:       return (l == tab + 1) ? 8'd2 : 8'd0;
            default: return 8'((l * 73 + tab * 29 + 17) & 255);
        endcase
    endfunction

    task automatic load_tables(int pat);
        for (int t = 0; t < 4; t++)
            for (int l = 0; l < 16; l++)
                ram['h6C0 + 16 * t + l] = cnt_of((pat + t) % 6, t, l);
    endtask

    task automatic verify_entries(int tab, string req);
        logic [15:0] f = '0;
        logic [11:0] b = '0;
        logic [7:0]  c;
        for (int l = 0; l < 16; l++) begin
            c = ram['h6C0 + 16 * tab + l];
            lk_len_i = 4'(l);
            #1;
            chk(req, $sformatf("first code tab%0d len%0d", tab, l + 1), 32'(lk_first_o), 32'(f));
            chk("R4", $sformatf("symbol base tab%0d len%0d", tab, l + 1), 32'(lk_base_o), 32'(b));
            f = 16'((f + 16'(c)) << 1);
            b = 12'(b + 12'(c));
        end
    endtask

    task automatic build(int tab, bit poke);
        @(negedge clk);
        table_sel_i = 2'(tab);
        start_i = 1'b1;
        for (int k = 1; k <= 19; k++) begin
            @(negedge clk);
            if (k == 1) start_i = 1'b0;
            if (poke && k == 5) begin start_i = 1'b1; table_sel_i = 2'(tab ^ 1); end
            if (poke && k == 6) start_i = 1'b0;
            if (k <= 16) begin
                chk("R2", "read strobe", 32'(mem_rd_o), 32'd1);
                chk(poke ? "R6" : "R2", "read address", 32'(mem_addr_o), 32'('h6C0 + 16 * tab + k - 1));
                chk("R2", "busy", 32'(busy_o), 32'd1);
            end else if (k == 17) begin
                chk("R2", "read strobe after last", 32'(mem_rd_o), 32'd0);
            end
            chk("R5", $sformatf("done at cycle %0d", k), 32'(done_o), 32'(k == 18));
            if (k == 19) chk("R5", "busy after done", 32'(busy_o), 32'd0);
        end
    endtask

    initial begin
        for (int a = 0; a < 2048; a++) ram[a] = 8'((a * 37 + 11) & 255);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "done in reset", 32'(done_o), 32'd0);
        chk("R1", "busy in reset", 32'(busy_o), 32'd0);
        chk("R1", "read in reset", 32'(mem_rd_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int l = 0; l < 16; l++) begin
            lk_len_i = 4'(l);
            #1;
            chk("R1", "first code after reset", 32'(lk_first_o), 32'd0);
            chk("R1", "base after reset", 32'(lk_base_o), 32'd0);
        end
        // Sweep: patterns rotated across tables, each table built (R3, R8, R9)
        for (int p = 0; p < 6; p++) begin
            load_tables(p);
            for (int t = 0; t < 4; t++) begin
                build(t, 1'b0);
                verify_entries(t, "R3");
            end
        end
        // R6: start and select change during a build are ignored
        load_tables(5);
        build(2, 1'b1);
        verify_entries(2, "R6");
        // R7: entries hold while idle, even when RAM changes
        for (int a = 'h6C0; a < 'h700; a++) ram[a] = 8'hA5;
        repeat (10) @(negedge clk);
        load_tables(5);
        verify_entries(2, "R7");
        // R8: rebuild another table replaces every entry
        load_tables(2);
        build(1, 1'b0);
        verify_entries(1, "R8");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule